// File: doc/BRIEF.md
# Palette Lookup Pixel Unpacker

This block turns a stream of 16-bit frame buffer halfwords into a stream of 12-bit colours with 4 bits each for red, green and blue. In the indexed depths (1, 2, 4 or 8 bits per pixel) it cuts each halfword into 16, 8, 4 or 2 palette indices, starting at the least significant bits. Each index reads a 256-entry by 12-bit palette RAM, and the entry read is the pixel colour. In the direct depth (12/16 bits per pixel), or whenever the panel configuration forbids the palette, the halfword goes out as one pixel made of its lower 12 bits.

The halfword input uses a valid/ready handshake. Configuration (depth code, panel type, 24-bit flag) is captured with each accepted halfword. The palette is loaded through a simple write port. Output pixels come with a valid strobe, one per cycle, one cycle behind the unpacking stage because of the registered palette read.

Top module: `palette_pixel_unpacker`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Every accepted halfword yields exactly 16, 8, 4 or 2 output pixels at depth codes 000, 001, 010, 011 when lookup is on, and exactly one pixel otherwise.
- R3: At code 000 (1 bit per pixel) pixel k uses bit k of the halfword as the index, so only palette entries 0 and 1 are read; bit 0 goes first.
- R4: At code 001 (2 bits) pixel k uses bits [2k+1:2k]; at code 010 (4 bits) pixel k uses bits [4k+3:4k]; lowest field first.
- R5: At code 011 (8 bits) the low byte indexes the first pixel and the high byte the second, reaching all 256 entries.
- R6: Codes 100 to 111 bypass the palette: one pixel equal to the halfword's bits [11:0].
- R7: With `cfg_active_panel`=1 and `cfg_wide24`=1, codes 000 to 011 also bypass the palette as in R6.
- R8: With `cfg_active_panel`=0, `cfg_wide24` has no effect and codes 000 to 011 use the palette.
- R9: `in_ready` is 0 while a halfword still has pixels after the current one, and 1 in the cycle its final pixel is produced, so halfwords are accepted back to back with no idle cycle.
- R10: The first pixel of a halfword accepted at clock edge N appears on the outputs after edge N+1; pixel k after edge N+1+k.
- R11: A palette write (`pal_we`=1) updates the entry at that clock edge and every later lookup of that entry returns the new value.
- R12: Configuration and halfword data are captured at acceptance; changing them while the halfword is being unpacked has no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Depth code: 000/001/010/011 = 1/2/4/8 bits, 1xx = direct |
| cfg_active_panel | input | 1 | 1 = active-matrix panel, 0 = passive-matrix |
| cfg_wide24 | input | 1 | 24-bit output mode flag (blocks the palette on active panels) |
| in_valid | input | 1 | Halfword valid |
| in_ready | output | 1 | Halfword can be taken this cycle |
| in_word | input | 16 | Frame buffer halfword |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 8 | Palette write address |
| pal_wdata | input | 12 | Palette write data |
| out_valid | output | 1 | Output pixel valid |
| out_color | output | 12 | Output colour, 4 bits per component |

## Verification
A wrong pixel counter or a stale shift amount shows at the ports as a pixel sourced from the wrong field of the halfword, visible in the very next output cycle, or as a halfword producing too many or too few pixels, which shifts every later colour in the stream. A wrong lookup-enable decision shows as a palette colour where the raw lower 12 bits belong, one cycle after the halfword is taken. A broken ready signal shows either as a missed halfword or as a one-cycle bubble between halfwords, and a lost capture of the configuration shows as pixels that follow a configuration value that was only present after acceptance.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int WORD_W  = 16;
    localparam int IDX_W   = 8;
    localparam int COLOR_W = 12;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int LG_W    = 2;

    typedef enum logic [2:0] {
        DEPTH_1  = 3'b000,
        DEPTH_2  = 3'b001,
        DEPTH_4  = 3'b010,
        DEPTH_8  = 3'b011,
        DEPTH_16 = 3'b100
    } depth_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  last;
        logic [LG_W-1:0]   lg;
        logic              lut;
        logic              busy;
    } slice_t;

    typedef struct packed {
        logic               valid;
        logic               use_pal;
        logic [COLOR_W-1:0] raw;
    } outp_t;
endpackage

// File: rtl/pxu_mode_dec.sv
module pxu_mode_dec
    import pxu_pkg::*;
(
    input  logic [2:0]       depth,
    input  logic             active_panel,
    input  logic             wide24,
    output logic             lut_en,
    output logic [LG_W-1:0]  lg,
    output logic [CNT_W-1:0] last
);
    logic indexed;

    always_comb begin
        indexed = (depth[2] == 1'b0);
        lut_en  = indexed && !(active_panel && wide24);
        lg      = depth[LG_W-1:0];
        if (lut_en) begin
            last = CNT_W'((WORD_W >> lg) - 1);
        end else begin
            last = '0;
        end
    end
endmodule

// File: rtl/pxu_slicer.sv
module pxu_slicer
    import pxu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               dec_lut,
    input  logic [LG_W-1:0]    dec_lg,
    input  logic [CNT_W-1:0]   dec_last,
    output logic               pix_valid,
    output logic               pix_lut,
    output logic [IDX_W-1:0]   pix_idx,
    output logic [COLOR_W-1:0] pix_raw
);
    slice_t s_d, s_q;
    logic   is_last;
    logic   accept;
    logic [CNT_W:0]    shamt;
    logic [WORD_W-1:0] shifted;
    logic [IDX_W-1:0]  mask;

    always_comb begin
        is_last  = s_q.busy && (s_q.cnt == s_q.last);
        in_ready = !s_q.busy || is_last;
        accept   = in_valid && in_ready;

        s_d = s_q;
        if (s_q.busy) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (is_last) begin
                s_d.busy = 1'b0;
            end
        end
        if (accept) begin
            s_d.word = in_word;
            s_d.cnt  = '0;
            s_d.last = dec_last;
            s_d.lg   = dec_lg;
            s_d.lut  = dec_lut;
            s_d.busy = 1'b1;
        end

        shamt   = {1'b0, s_q.cnt} << s_q.lg;
        shifted = s_q.word >> shamt;
        case (s_q.lg)
            2'd0:    mask = IDX_W'(8'h01);
            2'd1:    mask = IDX_W'(8'h03);
            2'd2:    mask = IDX_W'(8'h0F);
            default: mask = IDX_W'(8'hFF);
        endcase

        pix_valid = s_q.busy;
        pix_lut   = s_q.lut;
        pix_idx   = shifted[IDX_W-1:0] & mask;
        pix_raw   = s_q.word[COLOR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: the pixel counter never runs past the final pixel of a halfword
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt <= s_q.last));

    // R9: a halfword with pixels left keeps the stage busy and advances by one
    a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !is_last) |=> (s_q.busy && s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R12: the held halfword does not change before its final pixel
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !is_last) |=> $stable(s_q.word));

    // R6: a bypassed halfword produces exactly one pixel
    a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec_lut) |=> (pix_valid && in_ready));
endmodule

// File: rtl/pxu_palette.sv
module pxu_palette
    import pxu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pal_we,
    input  logic [IDX_W-1:0]   pal_waddr,
    input  logic [COLOR_W-1:0] pal_wdata,
    input  logic               pix_valid,
    input  logic               pix_lut,
    input  logic [IDX_W-1:0]   pix_idx,
    input  logic [COLOR_W-1:0] pix_raw,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COLOR_W-1:0] mem [DEPTH];
    logic [COLOR_W-1:0] rd_q;
    outp_t o_d, o_q;

    always_ff @(posedge clk) begin
        if (pal_we) begin
            mem[pal_waddr] <= pal_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (pix_valid && pix_lut) begin
            rd_q <= mem[pix_idx];
        end
    end

    always_comb begin
        o_d.valid   = pix_valid;
        o_d.use_pal = pix_lut;
        o_d.raw     = pix_raw;
        out_valid   = o_q.valid;
        out_color   = o_q.use_pal ? rd_q : o_q.raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    // R10: each unpacked pixel appears exactly one cycle later
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    a_r10_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R6: bypassed pixels carry the lower 12 bits of the halfword
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_lut) |=> (out_color == $past(pix_raw)));
endmodule

// File: rtl/palette_pixel_unpacker.sv
module palette_pixel_unpacker
    import pxu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_depth,
    input  logic        cfg_active_panel,
    input  logic        cfg_wide24,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_word,
    input  logic        pal_we,
    input  logic [7:0]  pal_waddr,
    input  logic [11:0] pal_wdata,
    output logic        out_valid,
    output logic [11:0] out_color
);
    logic               dec_lut;
    logic [LG_W-1:0]    dec_lg;
    logic [CNT_W-1:0]   dec_last;
    logic               pix_valid;
    logic               pix_lut;
    logic [IDX_W-1:0]   pix_idx;
    logic [COLOR_W-1:0] pix_raw;

    pxu_mode_dec u_dec (
        .depth        (cfg_depth),
        .active_panel (cfg_active_panel),
        .wide24       (cfg_wide24),
        .lut_en       (dec_lut),
        .lg           (dec_lg),
        .last         (dec_last)
    );

    pxu_slicer u_slice (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .dec_lut   (dec_lut),
        .dec_lg    (dec_lg),
        .dec_last  (dec_last),
        .pix_valid (pix_valid),
        .pix_lut   (pix_lut),
        .pix_idx   (pix_idx),
        .pix_raw   (pix_raw)
    );

    pxu_palette u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .pal_we    (pal_we),
        .pal_waddr (pal_waddr),
        .pal_wdata (pal_wdata),
        .pix_valid (pix_valid),
        .pix_lut   (pix_lut),
        .pix_idx   (pix_idx),
        .pix_raw   (pix_raw),
        .out_valid (out_valid),
        .out_color (out_color)
    );

    // R7: an active panel in 24-bit mode never selects the palette
    a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_active_panel && cfg_wide24) |=> (pix_valid && !pix_lut));

    // R8: a passive panel with an indexed code always selects the palette
    a_r8_passive: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !cfg_active_panel && !cfg_depth[2]) |=> (pix_valid && pix_lut));
endmodule

// File: tb/palette_pixel_unpacker_test.sv
module palette_pixel_unpacker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_depth = 3'd0;
    logic        cfg_active_panel = 1'b0;
    logic        cfg_wide24 = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = 16'h0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_waddr = 8'h0;
    logic [11:0] pal_wdata = 12'h0;
    logic        out_valid;
    logic [11:0] out_color;

    int tests = 0;
    int fails = 0;
    logic [11:0] pal_m [256];
    logic [11:0] exp_c [$];
    string       exp_t [$];

    // fields: depth[20:18] active[17] wide24[16] word[15:0]
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {3'b000, 1'b1, 1'b0, 16'hA5C3},
        {3'b001, 1'b0, 1'b1, 16'h1B6E},
        {3'b010, 1'b1, 1'b0, 16'hF0E1},
        {3'b011, 1'b0, 1'b0, 16'h3C96},
        {3'b100, 1'b1, 1'b0, 16'hBEEF},
        {3'b011, 1'b1, 1'b1, 16'h1234},
        {3'b000, 1'b1, 1'b1, 16'hFFFF},
        {3'b010, 1'b0, 1'b1, 16'h8421},
        {3'b111, 1'b0, 1'b0, 16'hABCD},
        {3'b011, 1'b1, 1'b0, 16'h00FF}
    };

    palette_pixel_unpacker uut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .cfg_active_panel(cfg_active_panel), .cfg_wide24(cfg_wide24),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .out_valid(out_valid), .out_color(out_color)
    );

    always #2.5 clk = ~clk;

    function automatic string tag_of(input logic [2:0] d, input logic a, input logic w);
        if (d[2]) return "R6";
        if (a && w) return "R7";
        if (!a && w) return "R8";
        if (d == 3'b000) return "R3";
        if (d == 3'b011) return "R5";
        return "R4";
    endfunction

    function automatic void check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endfunction

    // push the expected pixels of one accepted halfword
    function automatic void expect_word(input logic [2:0] d, input logic a, input logic w,
                                        input logic [15:0] word, input string tag);
        if (!d[2] && !(a && w)) begin
            int bits = 1 << d;
            int n = 16 / bits;
            for (int k = 0; k < n; k++) begin
                int idx = (word >> (k * bits)) & ((1 << bits) - 1);
                exp_c.push_back(pal_m[idx]);
                exp_t.push_back(tag);
            end
        end else begin
            exp_c.push_back(word[11:0]);
            exp_t.push_back(tag);
        end
    endfunction

    task automatic send(input logic [2:0] d, input logic a, input logic w,
                        input logic [15:0] word, input string tag);
        @(negedge clk);
        cfg_depth = d; cfg_active_panel = a; cfg_wide24 = w;
        in_word = word; in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        expect_word(d, a, w, word, tag);
        #1;
        // R12: scramble configuration and data right after acceptance
        cfg_depth = ~d; cfg_active_panel = ~a; cfg_wide24 = ~w;
        in_word = ~word; in_valid = 1'b0;
    endtask

    task automatic pal_write(input logic [7:0] addr, input logic [11:0] data);
        @(negedge clk);
        pal_we = 1'b1; pal_waddr = addr; pal_wdata = data;
        @(negedge clk);
        pal_we = 1'b0;
        pal_m[addr] = data;
    endtask

    // output monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_c.size() == 0) begin
                tests++; fails++;
                $display("FAIL R2 actual=extra pixel %h expected=none", out_color);
            end else begin
                check(exp_t[0], {4'h0, out_color}, {4'h0, exp_c[0]});
                void'(exp_c.pop_front());
                void'(exp_t.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", {15'h0, out_valid}, 16'h0);
        check("R1 in_ready", {15'h0, in_ready}, 16'h1);

        for (int i = 0; i < 256; i++) pal_write(i[7:0], 12'((i * 41 + 7) & 12'hFFF));

        // table walk, back to back
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][20:18], VEC[v][17], VEC[v][16], VEC[v][15:0],
                 tag_of(VEC[v][20:18], VEC[v][17], VEC[v][16]));
        end
        repeat (40) @(negedge clk);

        // R10: latency of a single bypassed pixel from an idle pipeline
        send(3'b100, 1'b0, 1'b0, 16'h5A7C, "R10 value");
        @(negedge clk);
        check("R10 not yet valid", {15'h0, out_valid}, 16'h0);
        @(negedge clk);
        check("R10 valid", {15'h0, out_valid}, 16'h1);
        repeat (5) @(negedge clk);

        // R9: ready stays low for seven cycles of a 2-bit halfword
        send(3'b001, 1'b1, 1'b0, 16'hC639, "R9 pixel");
        n = 0;
        @(negedge clk); #1;
        while (!in_ready && n < 40) begin
            n++;
            @(negedge clk); #1;
        end
        check("R9 stall cycles", 16'(n), 16'd7);
        repeat (10) @(negedge clk);

        // R11: rewrite an entry, then look it up
        pal_write(8'h2A, 12'hD0B);
        send(3'b011, 1'b0, 1'b0, 16'h2A2A, "R11");
        repeat (10) @(negedge clk);

        // R12: 1-bit halfword followed by a scramble of the configuration
        send(3'b000, 1'b0, 1'b0, 16'h0F0F, "R12");
        repeat (30) @(negedge clk);

        check("R2 leftover pixels", 16'(exp_c.size()), 16'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule